// File: doc/BRIEF.md
# Saturating PI Controller with Selectable Anti-Windup

This block is a sampled fixed-point proportional-integral regulator. Each time the sample strobe is raised it takes one signed 16-bit error word, forms a proportional term and an integral increment from runtime gains, adds the proportional term to the running integrator, and presents two results: the unsaturated sum (held within the 16-bit word) and a copy clamped between runtime upper and lower limits. Two flags say which limit, if any, is active. Data words use a scale where one per-unit is 0x3FFF. Gains use 12 fractional bits, so 4096 is a gain of 1.0.

A two-bit mode input selects how the integrator behaves while the output sits on a limit. In the plain mode it keeps accumulating. In the conditional mode it is frozen for any sample whose output is on a limit, and accumulates again as soon as the output is back inside. In the tracking mode the amount by which the unsaturated output exceeds the clamped one is scaled by a third gain and subtracted from the integral increment. In every mode the integrator is a 24-bit register that sticks at its extremes and never wraps.

A small state machine sequences each sample. It has two states: IDLE, which waits for a strobe, and UPDATE, which forms the output and updates the integrator. The transition IDLE to UPDATE is taken on an accepted strobe. The transition UPDATE to IDLE is taken unconditionally on the next clock.

Top module: `pi_antiwindup`

## Requirements
- R1: A synchronous reset clears the integrator to 0 and drives y_raw_o, y_sat_o, sat_hi_o, sat_lo_o and valid_o to 0.
- R2: A strobe seen in IDLE is accepted. valid_o is a one-cycle pulse in the second cycle after the strobe cycle. A strobe in the cycle after an accepted strobe (state UPDATE) is ignored. Outputs change only together with valid_o.
- R3: The proportional term is floor(kp_i*err_i/4096) and the result y is that term plus the integrator value from before this sample's update. y_raw_o is y limited to [-32768, 32767].
- R4: sat_hi_o = (y >= ymax_i). sat_lo_o = !sat_hi_o && (y <= ymin_i). y_sat_o is ymax_i when sat_hi_o, ymin_i when sat_lo_o, and y otherwise.
- R5: In mode 0 (and in mode 3, which behaves the same) the integrator adds floor(ki_i*err_i/4096) on every sample, whatever the flags.
- R6: In mode 1 the integrator keeps its value on a sample where sat_hi_o or sat_lo_o is set, and adds the integral increment on a sample where neither is set.
- R7: In mode 2 the integrator adds the integral increment minus floor(klim_i*(y - y_sat)/4096).
- R8: The integrator stays within [-8388608, 8388607] and saturates at those bounds instead of wrapping.
- R9: Each gain product is limited to [-32768, 32767] before it is summed.
- R10: In mode 2, a run of samples that never reaches a limit gives the same outputs as the same run in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Sample strobe |
| err_i | input | 16 | Signed error sample |
| kp_i | input | 16 | Signed proportional gain, 12 fractional bits |
| ki_i | input | 16 | Signed integral gain per sample, 12 fractional bits |
| klim_i | input | 16 | Signed tracking feedback gain, 12 fractional bits |
| ymax_i | input | 16 | Signed upper output limit |
| ymin_i | input | 16 | Signed lower output limit |
| mode_i | input | 2 | 0 plain, 1 conditional, 2 tracking, 3 plain |
| y_raw_o | output | 16 | Unsaturated output, limited to the word |
| y_sat_o | output | 16 | Output clamped to the limits |
| sat_hi_o | output | 1 | Upper limit active |
| sat_lo_o | output | 1 | Lower limit active |
| valid_o | output | 1 | Output update pulse |

## Verification
The hardest state to reach is the integrator sitting on its own 24-bit bound, which lies far beyond anything the 16-bit output can show. The bench reaches it by driving both the integral gain and the error to full scale, so each product saturates at 32767, and strobing about 260 samples in plain mode. It then reverses the error and checks that the output stays at the top of the range instead of jumping negative. The other hard case is telling the three modes apart at the exact limit value. Error sequences are chosen so that the output lands exactly on ymax_i, and the integrator value is then read back with a zero-error sample.

// File: rtl/aw_pkg.sv
`timescale 1ns/1ps
package aw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_UPDATE = 1'b1
    } aw_state_t;

    localparam logic [1:0] MODE_PLAIN = 2'd0;
    localparam logic [1:0] MODE_COND  = 2'd1;
    localparam logic [1:0] MODE_TRACK = 2'd2;
endpackage

// File: rtl/aw_gain_mul.sv
`timescale 1ns/1ps
module aw_gain_mul #(
    parameter int AW = 16,
    parameter int BW = 16,
    parameter int OW = 16,
    parameter int SH = 12
) (
    input  logic signed [AW-1:0] a_i,
    input  logic signed [BW-1:0] b_i,
    output logic signed [OW-1:0] p_o
);
    localparam int PW = AW + BW;
    localparam logic signed [PW-1:0] P_HI = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [PW-1:0] P_LO = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shr;

    always_comb begin
        full = a_i * b_i;
        shr  = full >>> SH;   // floor toward negative infinity
        if (shr > P_HI)
            p_o = P_HI[OW-1:0];
        else if (shr < P_LO)
            p_o = P_LO[OW-1:0];
        else
            p_o = shr[OW-1:0];
    end
endmodule

// File: rtl/aw_limit.sv
`timescale 1ns/1ps
module aw_limit #(
    parameter int DW = 16,
    parameter int YW = 25,
    parameter int EW = 26
) (
    input  logic signed [YW-1:0] y_i,
    input  logic signed [DW-1:0] ymax_i,
    input  logic signed [DW-1:0] ymin_i,
    output logic signed [DW-1:0] y_sat_o,
    output logic signed [DW-1:0] y_raw_o,
    output logic                 hi_o,
    output logic                 lo_o,
    output logic signed [EW-1:0] excess_o
);
    localparam logic signed [YW-1:0] W_HI = {{(YW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [YW-1:0] W_LO = {{(YW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [YW-1:0] ymax_e, ymin_e, ysat_e;
    logic signed [EW-1:0] y_x, ysat_x;

    always_comb begin
        ymax_e = {{(YW-DW){ymax_i[DW-1]}}, ymax_i};
        ymin_e = {{(YW-DW){ymin_i[DW-1]}}, ymin_i};
        hi_o   = (y_i >= ymax_e);
        lo_o   = !hi_o && (y_i <= ymin_e);
        if (hi_o)
            ysat_e = ymax_e;
        else if (lo_o)
            ysat_e = ymin_e;
        else
            ysat_e = y_i;
        y_sat_o  = ysat_e[DW-1:0];
        y_x      = {{(EW-YW){y_i[YW-1]}}, y_i};
        ysat_x   = {{(EW-YW){ysat_e[YW-1]}}, ysat_e};
        excess_o = y_x - ysat_x;
        if (y_i > W_HI)
            y_raw_o = W_HI[DW-1:0];
        else if (y_i < W_LO)
            y_raw_o = W_LO[DW-1:0];
        else
            y_raw_o = y_i[DW-1:0];
    end
endmodule

// File: rtl/aw_integrator.sv
`timescale 1ns/1ps
module aw_integrator
    import aw_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int GFRAC = 12,
    parameter int ACC_W = 24,
    parameter int EW    = 26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_i,
    input  logic [1:0]              mode_i,
    input  logic                    sat_i,
    input  logic signed [DW-1:0]    iterm_i,
    input  logic signed [EW-1:0]    excess_i,
    input  logic signed [GW-1:0]    klim_i,
    output logic signed [ACC_W-1:0] integ_o
);
    localparam int FW = ACC_W + 2;
    localparam int SW = ACC_W + 4;
    localparam logic signed [SW-1:0] A_HI = {{(SW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SW-1:0] A_LO = {{(SW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    logic signed [FW-1:0]    fb;
    logic signed [SW-1:0]    iterm_x, fb_x, integ_x, delta, sum;
    logic signed [ACC_W-1:0] integ_q, integ_d;

    aw_gain_mul #(.AW(GW), .BW(EW), .OW(FW), .SH(GFRAC)) u_klim (
        .a_i(klim_i), .b_i(excess_i), .p_o(fb)
    );

    always_comb begin
        iterm_x = {{(SW-DW){iterm_i[DW-1]}}, iterm_i};
        fb_x    = {{(SW-FW){fb[FW-1]}}, fb};
        integ_x = {{(SW-ACC_W){integ_q[ACC_W-1]}}, integ_q};
        case (mode_i)
            MODE_COND:  delta = sat_i ? '0 : iterm_x;
            MODE_TRACK: delta = iterm_x - fb_x;
            default:    delta = iterm_x;
        endcase
        sum = integ_x + delta;
        if (sum > A_HI)
            integ_d = A_HI[ACC_W-1:0];
        else if (sum < A_LO)
            integ_d = A_LO[ACC_W-1:0];
        else
            integ_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            integ_q <= '0;
        else if (upd_i)
            integ_q <= integ_d;
    end

    assign integ_o = integ_q;

    AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (upd_i && mode_i == MODE_COND && sat_i) |=> $stable(integ_q)); // R6

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !integ_q[ACC_W-1] && !delta[SW-1]) |=> !integ_q[ACC_W-1]); // R8

    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
        (upd_i && integ_q[ACC_W-1] && delta[SW-1]) |=> integ_q[ACC_W-1]); // R8
endmodule

// File: rtl/pi_antiwindup.sv
`timescale 1ns/1ps
module pi_antiwindup
    import aw_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int GFRAC = 12,
    parameter int ACC_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] err_i,
    input  logic signed [GW-1:0] kp_i,
    input  logic signed [GW-1:0] ki_i,
    input  logic signed [GW-1:0] klim_i,
    input  logic signed [DW-1:0] ymax_i,
    input  logic signed [DW-1:0] ymin_i,
    input  logic [1:0]           mode_i,
    output logic signed [DW-1:0] y_raw_o,
    output logic signed [DW-1:0] y_sat_o,
    output logic                 sat_hi_o,
    output logic                 sat_lo_o,
    output logic                 valid_o
);
    localparam int YW = ACC_W + 1;
    localparam int EW = YW + 1;

    aw_state_t state_q, state_d;
    logic accept, upd;

    logic signed [DW-1:0]    p_c, i_c, p_q, i_q;
    logic signed [ACC_W-1:0] integ;
    logic signed [YW-1:0]    y_full;
    logic signed [DW-1:0]    ysat_c, yraw_c;
    logic                    hi_c, lo_c;
    logic signed [EW-1:0]    excess_c;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sample_i) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && sample_i;
    assign upd    = (state_q == ST_UPDATE);

    aw_gain_mul #(.AW(GW), .BW(DW), .OW(DW), .SH(GFRAC)) u_kp (
        .a_i(kp_i), .b_i(err_i), .p_o(p_c)
    );
    aw_gain_mul #(.AW(GW), .BW(DW), .OW(DW), .SH(GFRAC)) u_ki (
        .a_i(ki_i), .b_i(err_i), .p_o(i_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
            i_q <= '0;
        end else if (accept) begin
            p_q <= p_c;
            i_q <= i_c;
        end
    end

    assign y_full = $signed({{(YW-DW){p_q[DW-1]}}, p_q}) + $signed({integ[ACC_W-1], integ});

    aw_limit #(.DW(DW), .YW(YW), .EW(EW)) u_limit (
        .y_i(y_full), .ymax_i(ymax_i), .ymin_i(ymin_i),
        .y_sat_o(ysat_c), .y_raw_o(yraw_c),
        .hi_o(hi_c), .lo_o(lo_c), .excess_o(excess_c)
    );

    aw_integrator #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .ACC_W(ACC_W), .EW(EW)) u_integ (
        .clk(clk), .rst(rst), .upd_i(upd), .mode_i(mode_i),
        .sat_i(hi_c || lo_c), .iterm_i(i_q), .excess_i(excess_c),
        .klim_i(klim_i), .integ_o(integ)
    );

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            y_raw_o  <= '0;
            y_sat_o  <= '0;
            sat_hi_o <= 1'b0;
            sat_lo_o <= 1'b0;
        end else begin
            valid_o <= upd;
            if (upd) begin
                y_raw_o  <= yraw_c;
                y_sat_o  <= ysat_c;
                sat_hi_o <= hi_c;
                sat_lo_o <= lo_c;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(accept, 2)); // R2

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(y_sat_o) && $stable(y_raw_o) && $stable(sat_hi_o))); // R2

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ymin_i <= ymax_i && $stable(ymax_i) && $stable(ymin_i))
        |-> (y_sat_o <= ymax_i && y_sat_o >= ymin_i)); // R4
endmodule

// File: tb/pi_antiwindup_test.sv
`timescale 1ns/1ps
module pi_antiwindup_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample = 1'b0;
    logic signed [15:0] err = '0, kp = '0, ki = '0, klim = '0;
    logic signed [15:0] ymax = 16'sd16383, ymin = -16'sd16383;
    logic [1:0] mode = 2'd0;
    logic signed [15:0] y_raw, y_sat;
    logic hi, lo, valid;

    int n_run = 0;
    int n_fail = 0;
    longint m_integ = 0;
    longint rec [0:7];

    always #2.5 clk = ~clk;

    pi_antiwindup uut (
        .clk(clk), .rst(rst), .sample_i(sample), .err_i(err),
        .kp_i(kp), .ki_i(ki), .klim_i(klim), .ymax_i(ymax), .ymin_i(ymin),
        .mode_i(mode), .y_raw_o(y_raw), .y_sat_o(y_sat),
        .sat_hi_o(hi), .sat_lo_o(lo), .valid_o(valid)
    );

    function automatic longint satw(input longint v, input int w);
        longint top = (longint'(1) <<< (w-1)) - 1;
        longint bot = -(longint'(1) <<< (w-1));
        return (v > top) ? top : (v < bot) ? bot : v;
    endfunction

    function automatic longint mulq(input longint g, input longint e);
        return satw((g * e) >>> 12, 16);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; sample = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_integ = 0;
    endtask

    // one sample, compared with the requirement model; returns model y_raw
    task automatic step(input longint e, input string tag, output longint raw_exp);
        longint p, it, y, ys, ex, d, fb;
        bit mh, ml;
        @(negedge clk); err = 16'(e); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        if (valid !== 1'b0) check({tag, "/R2 early valid"}, valid, 0);
        @(negedge clk);
        p  = mulq(kp, e);
        it = mulq(ki, e);
        y  = p + m_integ;
        mh = (y >= ymax);
        ml = !mh && (y <= ymin);
        ys = mh ? ymax : ml ? ymin : y;
        raw_exp = satw(y, 16);
        ex = y - ys;
        case (mode)
            2'd1: d = (mh || ml) ? 0 : it;
            2'd2: begin fb = satw((klim * ex) >>> 12, 26); d = it - fb; end
            default: d = it;
        endcase
        m_integ = satw(m_integ + d, 24);
        check({tag, " valid"}, valid, 1);
        check({tag, " y_raw"}, y_raw, raw_exp);
        check({tag, " y_sat/flags"}, {longint'(y_sat), longint'(hi), longint'(lo)} == {ys, longint'(mh), longint'(ml)} ? 1 : 0, 1);
    endtask

    task automatic t_reset;
        check("R1 valid", valid, 0);
        check("R1 y_raw", y_raw, 0);
        check("R1 y_sat", y_sat, 0);
        check("R1 flags", {hi, lo}, 0);
    endtask

    task automatic t_plain;
        longint r;
        mode = 2'd0; kp = 16'sd4096; ki = 16'sd1024;
        step(1000, "R3/R5 a", r); check("R3 first value", r, 1000);
        step(1000, "R3/R5 b", r); check("R5 accumulated", r, 1250);
        step(-3000, "R3/R5 c", r);
        step(5, "R3/R5 d", r);
        kp = 16'sd1365; ki = 16'sd0;
        do_reset();
        step(-3, "R3 floor", r); check("R3 floor -4095/4096", r, -1);
        mode = 2'd3; ki = 16'sd4096; kp = 16'sd0;
        step(200, "R5 mode3 a", r);
        step(0, "R5 mode3 b", r); check("R5 mode3 acc", r, 200);
    endtask

    task automatic t_prodsat;
        longint r;
        do_reset();
        mode = 2'd0; kp = 16'sd32767; ki = 16'sd0; ymax = 16'sd32767; ymin = -16'sd32768;
        step(20000, "R9 pos", r); check("R9 kp product limited", r, 32767);
        step(-20000, "R9 neg", r); check("R9 kp product limited neg", r, -32768);
        ymax = 16'sd16383; ymin = -16'sd16383;
    endtask

    task automatic t_cond;
        longint r;
        do_reset();
        mode = 2'd1; kp = 16'sd4096; ki = 16'sd4096; ymax = 16'sd2000; ymin = -16'sd2000;
        step(1000, "R6 a", r);
        step(1000, "R6 b at limit", r); check("R6 hi at equality", hi, 1);
        step(1000, "R6 c", r);
        step(0, "R6 read", r); check("R6 held integrator", r, 1000);
        step(-500, "R6 resume", r);
        step(0, "R6 read2", r); check("R6 resumed", r, 500);
        step(-4000, "R6 lo", r); check("R4 lo flag", lo, 1);
        step(0, "R6 read3", r); check("R6 held on lo", r, 500);
    endtask

    task automatic t_track;
        longint r;
        do_reset();
        mode = 2'd2; kp = 16'sd4096; ki = 16'sd4096; klim = 16'sd4096;
        ymax = 16'sd2000; ymin = -16'sd2000;
        step(1000, "R7 a", r);
        step(1000, "R7 b", r);
        step(1000, "R7 c", r); check("R7 y_sat clamp", y_sat, 2000);
        step(0, "R7 read", r); check("R7 back-calc integrator", r, 2000);
        ymax = 16'sd16383; ymin = -16'sd16383;
    endtask

    task automatic t_track_plain;
        longint r;
        longint seq [0:7] = '{300, -120, 77, 900, -1500, 4, 0, 650};
        kp = 16'sd3000; ki = 16'sd700; klim = 16'sd8000;
        do_reset(); mode = 2'd2;
        foreach (seq[i]) begin step(seq[i], "R10 track", r); rec[i] = longint'(y_raw); end
        do_reset(); mode = 2'd0;
        foreach (seq[i]) begin step(seq[i], "R10 plain", r); check("R10 same as plain", y_raw, rec[i]); end
    endtask

    task automatic t_bound;
        longint r;
        do_reset();
        mode = 2'd0; kp = 16'sd0; ki = 16'sd32767;
        for (int k = 0; k < 260; k++) step(32767, "R8 climb", r);
        check("R8 integrator at bound", m_integ, 8388607);
        err = '0;
        step(-32768, "R8 reverse", r);
        check("R8 no wrap after reverse", y_raw, 32767);
        check("R8 hi flag kept", hi, 1);
    endtask

    task automatic t_busy;
        longint r;
        int pulses = 0;
        do_reset();
        mode = 2'd0; kp = 16'sd0; ki = 16'sd4096;
        @(negedge clk); err = 16'sd100; sample = 1'b1;
        @(negedge clk);             // accepted; strobe still high during UPDATE
        @(negedge clk); sample = 1'b0;
        if (valid) pulses++;
        @(negedge clk); if (valid) pulses++;
        @(negedge clk); if (valid) pulses++;
        check("R2 one pulse for held strobe", pulses, 1);
        m_integ = 100;
        step(0, "R2 read", r); check("R2 single update", r, 100);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_plain();
        t_prodsat();
        t_cond();
        t_track();
        t_track_plain();
        t_bound();
        t_busy();
        do_reset();
        check("R1 reset after run", y_raw, 0);
        check("R1 valid after reset", valid, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule